// File: doc/BRIEF.md
# Four-Channel Compare-Match PWM Timer

This block holds four independent 16-bit up-counters. Each one drives a single output pin. A channel counts on ticks taken from a shared free-running prescaler. Every tick it compares its counter against four compare registers. One selectable compare clears the counter, which sets the period. A match on compare A changes the pin level according to a per-channel output code. In PWM mode the clearing match also returns the pin to its programmed initial level. Compare A then sets the duty point and the clearing compare sets the period.

Software reaches all state through a 16-bit register bus. The bus has a write strobe and a combinational read path. A shared run register sits at address 0x00. Channel n has a window at 0x10 + n*0x40. A stopped channel drives its initial level as a static output. Software uses this to hold a fixed 0% or 100% output without the counter running. Compare A may be rewritten while the channel runs, which changes the duty alone.

Top module: `mcpwm_timer`

## Requirements
- R1: After reset every register reads 0, every counter is 0 and every pin output is 0.
- R2: Bit n of the run register (address 0x00, read back in bits [3:0]) runs channel n when 1. When 0 the channel halts and its counter keeps its value. Channels never affect one another.
- R3: Channel n's window starts at 0x10 + n*0x40. It holds these word registers:
  - control at offset 0x00, bits [7:0]
  - mode at 0x04, bits [1:0]
  - output code at 0x08, bits [2:0]
  - counter at 0x14
  - compares A, B, C and D at 0x18, 0x1C, 0x20 and 0x24

  Offsets 0x0C and 0x10 and all other addresses read 0 and ignore writes.
- R4: Control bits [2:0] set the tick rate to the system clock divided by 1, 4, 16 or 64, for codes 0, 1, 2 and 3. Codes 4 to 7 also divide by 64.
- R5: Control bits [4:3] select the tick edge of the divided clock. 0 is rising, 1 is falling and 2 or 3 is both. Both doubles the tick rate for divisors above 1, and divide-by-1 ticks every cycle under any edge code.
- R6: Control bits [7:5] select the clear source: 1 is a match on A, 2 on B, 5 on C and 6 on D. Other codes never clear. A counter cleared on compare value N runs N+1 ticks per period. With no clear source the counter wraps from 0xFFFF to 0.
- R7: Output code bit 2 is the initial pin level. Bits [1:0] give the action taken on a tick where the counter equals compare A: 0 keeps the level, 1 drives low, 2 drives high and 3 toggles.
- R8: Mode code 2 selects PWM. Any other code selects normal counting. In PWM mode a tick that clears the counter without an A match returns the pin to its initial level. For a clear on B with A < B, the pin holds its initial level for counter values 0..A and the A-action level for A+1..B. When A equals B the A action wins, so initial 0 with set gives a constant 1.
- R9: A stopped channel drives its output-code initial level on its pin, and it starts again from that level.
- R10: Writing compare A on a running channel changes the duty from the next compare. It neither resets the counter nor changes the period.
- R11: Software may write the counter while the channel is stopped. A restarted channel continues from its current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Byte address of the word register |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i, combinational |
| pwm_o | output | 4 | Pin output of each channel |

## Verification
The bench aims at the off-by-one corners of the period and duty.
- A period one tick too long or short would surface as a wrong counter residue after a whole number of clear cycles.
- A misplaced restore or an inverted action would shift the high count measured over ten PWM periods.
- Swapping the priority of the A action and the restore on a coincident match would turn 100% duty into 0%.

Other targets are the prescaler phase and the edge code, which would show as a wrong tick count over a window of 256 cycles. A compare-A update that restarted the counter, and a pin that failed to return to its initial level on stop, are also checked.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
  localparam int unsigned DW  = 16;
  localparam int unsigned PSW = 6;

  localparam logic [3:0] W_CTRL = 4'd0;
  localparam logic [3:0] W_MODE = 4'd1;
  localparam logic [3:0] W_OUTC = 4'd2;
  localparam logic [3:0] W_CNT  = 4'd5;
  localparam logic [3:0] W_CMPA = 4'd6;
  localparam logic [3:0] W_CMPB = 4'd7;
  localparam logic [3:0] W_CMPC = 4'd8;
  localparam logic [3:0] W_CMPD = 4'd9;

  localparam logic [1:0] MODE_PWM = 2'd2;

  typedef struct packed {
    logic [2:0] clr;
    logic [1:0] edge_sel;
    logic [2:0] psc;
  } ctrl_t;

  // tick qualifier from the shared prescaler phase
  function automatic logic tick_sel(logic [PSW-1:0] pre, logic [2:0] psc, logic [1:0] edge_sel);
    logic [PSW-1:0] mask;
    logic [PSW-1:0] low;
    logic [PSW-1:0] half;
    logic rise;
    logic fall;
    case (psc)
      3'd0:    mask = '0;
      3'd1:    mask = PSW'(3);
      3'd2:    mask = PSW'(15);
      default: mask = PSW'(63);
    endcase
    low  = pre & mask;
    half = (mask >> 1) + PSW'(1);
    rise = (low == '0);
    fall = (low == half);
    if (mask == '0) return 1'b1;
    case (edge_sel)
      2'd0:    return rise;
      2'd1:    return fall;
      default: return rise | fall;
    endcase
  endfunction
endpackage

// File: rtl/mcpwm_prescaler.sv
module mcpwm_prescaler
  import mcpwm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  output logic [PSW-1:0] pre_o
);
  logic [PSW-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + PSW'(1);
  end

  assign pre_o = pre_q;
endmodule

// File: rtl/mcpwm_regif.sv
module mcpwm_regif #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8,
  localparam int unsigned CIW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           we_i,
  input  logic [AW-1:0]  addr_i,
  output logic           start_sel_o,
  output logic           start_we_o,
  output logic           ch_hit_o,
  output logic [CIW-1:0] ch_idx_o,
  output logic [3:0]     widx_o,
  output logic [NCH-1:0] ch_we_o
);
  localparam logic [AW-1:0] BASE = AW'(8'h10);
  localparam logic [5:0]    LAST = 6'h24;

  logic [AW-1:0] rel;
  logic          in_range;

  assign rel         = addr_i - BASE;
  assign in_range    = ({1'b0, rel[AW-1:6]} < NCH[AW-6:0]);
  assign ch_hit_o    = (addr_i >= BASE) && in_range && (rel[5:0] <= LAST) && (rel[1:0] == 2'b00);
  assign ch_idx_o    = rel[6 +: CIW];
  assign widx_o      = rel[5:2];
  assign start_sel_o = (addr_i == '0);
  assign start_we_o  = we_i && start_sel_o;

  for (genvar i = 0; i < NCH; i++) begin : g_we
    localparam logic [CIW-1:0] IDX = CIW'(i);
    assign ch_we_o[i] = we_i && ch_hit_o && (ch_idx_o == IDX);
  end
endmodule

// File: rtl/mcpwm_channel.sv
module mcpwm_channel
  import mcpwm_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic [PSW-1:0] pre_i,
  input  logic           we_i,
  input  logic [3:0]     widx_i,
  input  logic [DW-1:0]  wdata_i,
  output logic [DW-1:0]  rdata_o,
  output logic           pin_o
);
  ctrl_t            ctrl_q;
  logic [1:0]       mode_q;
  logic [2:0]       outc_q;
  logic [DW-1:0]    cnt_q;
  logic [3:0][DW-1:0] cmp_q;
  logic             pin_q;

  logic tick, a_hit, clr_hit, pwm_mode, cnt_we, outc_we, init_lvl, act_lvl;

  assign tick     = run_i && tick_sel(pre_i, ctrl_q.psc, ctrl_q.edge_sel);
  assign a_hit    = (cnt_q == cmp_q[0]);
  assign pwm_mode = (mode_q == MODE_PWM);
  assign cnt_we   = we_i && (widx_i == W_CNT);
  assign outc_we  = we_i && (widx_i == W_OUTC);
  assign init_lvl = outc_q[2];

  always_comb begin
    case (ctrl_q.clr)
      3'd1:    clr_hit = (cnt_q == cmp_q[0]);
      3'd2:    clr_hit = (cnt_q == cmp_q[1]);
      3'd5:    clr_hit = (cnt_q == cmp_q[2]);
      3'd6:    clr_hit = (cnt_q == cmp_q[3]);
      default: clr_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (outc_q[1:0])
      2'd0:    act_lvl = pin_q;
      2'd1:    act_lvl = 1'b0;
      2'd2:    act_lvl = 1'b1;
      default: act_lvl = ~pin_q;
    endcase
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      outc_q <= '0;
      cmp_q  <= '0;
    end else if (we_i) begin
      case (widx_i)
        W_CTRL: ctrl_q   <= ctrl_t'(wdata_i[7:0]);
        W_MODE: mode_q   <= wdata_i[1:0];
        W_OUTC: outc_q   <= wdata_i[2:0];
        W_CMPA: cmp_q[0] <= wdata_i;
        W_CMPB: cmp_q[1] <= wdata_i;
        W_CMPC: cmp_q[2] <= wdata_i;
        W_CMPD: cmp_q[3] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (cnt_we)  cnt_q <= wdata_i;
    else if (tick)    cnt_q <= clr_hit ? '0 : cnt_q + DW'(1);
  end

  // A action has priority over the period restore
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pin_q <= 1'b0;
    else if (!run_i)                pin_q <= init_lvl;
    else if (tick && a_hit)         pin_q <= act_lvl;
    else if (tick && clr_hit && pwm_mode) pin_q <= init_lvl;
  end

  assign pin_o = run_i ? pin_q : init_lvl;

  always_comb begin
    case (widx_i)
      W_CTRL:  rdata_o = {8'h00, ctrl_q};
      W_MODE:  rdata_o = {14'h0, mode_q};
      W_OUTC:  rdata_o = {13'h0, outc_q};
      W_CNT:   rdata_o = cnt_q;
      W_CMPA:  rdata_o = cmp_q[0];
      W_CMPB:  rdata_o = cmp_q[1];
      W_CMPC:  rdata_o = cmp_q[2];
      W_CMPD:  rdata_o = cmp_q[3];
      default: rdata_o = '0;
    endcase
  end

  a_r2_hold_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_we) |=> $stable(cnt_q));
  a_r6_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && clr_hit && !cnt_we) |=> (cnt_q == '0));
  a_r6_count_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !clr_hit && !cnt_we) |=> (cnt_q == $past(cnt_q) + DW'(1)));
  a_r7_keep_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && a_hit && outc_q[1:0] == 2'd0 && !outc_we) |=> (pin_q == $past(pin_q)));
  a_r8_restore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode && tick && clr_hit && !a_hit && !outc_we) |=> (pin_o == outc_q[2]));
endmodule

// File: rtl/mcpwm_timer.sv
module mcpwm_timer
  import mcpwm_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bus_we_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [DW-1:0]  bus_wdata_i,
  output logic [DW-1:0]  bus_rdata_o,
  output logic [NCH-1:0] pwm_o
);
  localparam int unsigned CIW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [PSW-1:0]         pre;
  logic                   start_sel, start_we, ch_hit;
  logic [CIW-1:0]         ch_idx;
  logic [3:0]             widx;
  logic [NCH-1:0]         ch_we;
  logic [NCH-1:0]         start_q;
  logic [NCH-1:0][DW-1:0] ch_rdata;

  mcpwm_prescaler u_psc (.clk_i(clk_i), .rst_ni(rst_ni), .pre_o(pre));

  mcpwm_regif #(.NCH(NCH), .AW(AW)) u_regif (
    .we_i(bus_we_i), .addr_i(bus_addr_i), .start_sel_o(start_sel),
    .start_we_o(start_we), .ch_hit_o(ch_hit), .ch_idx_o(ch_idx),
    .widx_o(widx), .ch_we_o(ch_we));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       start_q <= '0;
    else if (start_we) start_q <= bus_wdata_i[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    mcpwm_channel u_ch (
      .clk_i(clk_i), .rst_ni(rst_ni), .run_i(start_q[i]), .pre_i(pre),
      .we_i(ch_we[i]), .widx_i(widx), .wdata_i(bus_wdata_i),
      .rdata_o(ch_rdata[i]), .pin_o(pwm_o[i]));
  end

  always_comb begin
    if (start_sel)   bus_rdata_o = {{(DW-NCH){1'b0}}, start_q};
    else if (ch_hit) bus_rdata_o = ch_rdata[ch_idx];
    else             bus_rdata_o = '0;
  end

  a_r2_run_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_we |=> (start_q == $past(bus_wdata_i[NCH-1:0])));
  a_r3_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_we, ch_we}));
endmodule

// File: tb/sim_mcpwm_timer.sv
module sim_mcpwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [3:0]  pwm;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mcpwm_timer u0 (.clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
                  .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pwm_o(pwm));

  function automatic logic [7:0] ra(int ch, int w);
    return 8'(16 + ch * 64 + w * 4);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int d);
    @(negedge clk); addr = a; #1; d = int'(rdata);
  endtask

  // channel mask runs for exactly n clock edges
  task automatic run_win(logic [15:0] mask, int n);
    wr(8'h00, mask);
    repeat (n - 2) @(negedge clk);
    wr(8'h00, 16'h0);
  endtask

  task automatic high_count(int ch, int n, output int hi, output int rises);
    logic prev;
    hi = 0; rises = 0;
    @(negedge clk); #1; prev = pwm[ch];
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
      if (pwm[ch]) hi++;
      if (pwm[ch] && !prev) rises++;
      prev = pwm[ch];
    end
  endtask

  task automatic t_reset;
    int v;
    rd(8'h00, v);      chk("R1 run reg", v, 0);
    rd(ra(0, 0), v);   chk("R1 ctrl", v, 0);
    rd(ra(3, 9), v);   chk("R1 cmpD", v, 0);
    rd(ra(1, 5), v);   chk("R1 counter", v, 0);
    chk("R1 pins", int'(pwm), 0);
  endtask

  task automatic t_regmap;
    int v;
    wr(ra(2, 0), 16'hFFFF); rd(ra(2, 0), v); chk("R3 ctrl mask", v, 16'h00FF);
    wr(ra(2, 1), 16'hFFFF); rd(ra(2, 1), v); chk("R3 mode mask", v, 3);
    wr(ra(2, 2), 16'hFFFF); rd(ra(2, 2), v); chk("R3 outc mask", v, 7);
    wr(ra(2, 3), 16'hFFFF); rd(ra(2, 3), v); chk("R3 offset 0x0C", v, 0);
    wr(ra(2, 4), 16'hFFFF); rd(ra(2, 4), v); chk("R3 offset 0x10", v, 0);
    wr(ra(3, 9), 16'hBEEF); rd(ra(3, 9), v); chk("R3 cmpD ch3", v, 16'hBEEF);
    wr(8'h3C, 16'h1234);    rd(8'h3C, v);    chk("R3 unmapped", v, 0);
    wr(ra(2, 0), 16'h0); wr(ra(2, 1), 16'h0);
  endtask

  task automatic t_static;
    chk("R9 static high", int'(pwm[2]), 1);
    wr(ra(2, 2), 16'h0);
    chk("R9 static low", int'(pwm[2]), 0);
  endtask

  task automatic psc_case(string req, logic [15:0] ctrl, int exp);
    int v;
    wr(ra(0, 5), 16'h0); wr(ra(0, 0), ctrl);
    run_win(16'h1, 256);
    rd(ra(0, 5), v); chk(req, v, exp);
  endtask

  task automatic t_prescale;
    psc_case("R4 div1", 16'h00, 256);
    psc_case("R4 div4", 16'h01, 64);
    psc_case("R4 div16", 16'h02, 16);
    psc_case("R4 div64", 16'h03, 4);
    psc_case("R4 code4", 16'h04, 4);
    psc_case("R5 falling div16", 16'h0A, 16);
    psc_case("R5 both div16", 16'h12, 32);
    psc_case("R5 both div1", 16'h10, 256);
    psc_case("R5 falling div1", 16'h08, 256);
  endtask

  task automatic t_clear;
    int v;
    wr(ra(0, 0), 16'h00); wr(ra(0, 5), 16'hFFFE);
    run_win(16'h1, 4);
    rd(ra(0, 5), v); chk("R6 wrap", v, 2);
    wr(ra(0, 6), 9); wr(ra(0, 7), 14); wr(ra(0, 8), 6); wr(ra(0, 9), 30);
    psc_case("R6 clear A", 16'h20, 6);
    psc_case("R6 clear B", 16'h40, 1);
    psc_case("R6 clear C", 16'hA0, 4);
    psc_case("R6 clear D", 16'hC0, 8);
    psc_case("R6 code3 none", 16'h60, 256);
  endtask

  task automatic t_normal;
    int hi, rs;
    wr(ra(3, 0), 16'h40); wr(ra(3, 1), 0); wr(ra(3, 6), 3); wr(ra(3, 7), 7);
    wr(ra(3, 2), 3'b011); wr(ra(3, 5), 0); wr(8'h00, 16'h8);
    repeat (20) @(negedge clk);
    high_count(3, 128, hi, rs); chk("R7 toggle", hi, 64);
    wr(8'h00, 0);
    wr(ra(3, 2), 3'b010); wr(ra(3, 5), 0); wr(8'h00, 16'h8);
    repeat (20) @(negedge clk); #1; chk("R7 set", int'(pwm[3]), 1);
    wr(8'h00, 0);
    wr(ra(3, 2), 3'b101); wr(ra(3, 5), 0); wr(8'h00, 16'h8);
    repeat (20) @(negedge clk); #1; chk("R7 clear", int'(pwm[3]), 0);
    wr(8'h00, 0);
    wr(ra(3, 2), 3'b100); wr(ra(3, 5), 0); wr(8'h00, 16'h8);
    repeat (20) @(negedge clk); #1; chk("R7 keep", int'(pwm[3]), 1);
    wr(8'h00, 0);
  endtask

  task automatic t_pwm;
    int hi, rs, c0, c1;
    wr(ra(1, 0), 16'h40); wr(ra(1, 1), 2); wr(ra(1, 6), 3); wr(ra(1, 7), 9);
    wr(ra(1, 2), 3'b010); wr(ra(1, 5), 0); wr(8'h00, 16'h2);
    repeat (20) @(negedge clk);
    high_count(1, 100, hi, rs);
    chk("R8 duty 6/10", hi, 60); chk("R8 period", rs, 10);
    rd(ra(1, 5), c0);
    wr(ra(1, 6), 6);
    rd(ra(1, 5), c1);
    chk("R10 counter kept", c1, (c0 + 3) % 10);
    repeat (20) @(negedge clk);
    high_count(1, 100, hi, rs);
    chk("R10 new duty", hi, 30); chk("R10 period kept", rs, 10);
    wr(8'h00, 0); #1;
    chk("R9 stop low", int'(pwm[1]), 0);
    wr(ra(1, 6), 3); wr(ra(1, 2), 3'b101); wr(ra(1, 5), 0); wr(8'h00, 16'h2);
    repeat (20) @(negedge clk);
    high_count(1, 100, hi, rs); chk("R8 inverted", hi, 40);
    wr(8'h00, 0); #1;
    chk("R9 stop high", int'(pwm[1]), 1);
    wr(ra(1, 6), 9); wr(ra(1, 2), 3'b010); wr(ra(1, 5), 0); wr(8'h00, 16'h2);
    repeat (30) @(negedge clk);
    high_count(1, 100, hi, rs); chk("R8 A equals B", hi, 100);
    wr(8'h00, 0);
  endtask

  task automatic t_resume;
    int v;
    wr(ra(0, 0), 16'h00); wr(ra(0, 5), 100);
    run_win(16'h1, 256); rd(ra(0, 5), v); chk("R11 first run", v, 356);
    run_win(16'h1, 256); rd(ra(0, 5), v); chk("R11 resumed", v, 612);
  endtask

  task automatic t_indep;
    int v;
    wr(ra(0, 5), 0); wr(ra(1, 0), 16'h00); wr(ra(1, 5), 5);
    run_win(16'h2, 64);
    rd(ra(1, 5), v); chk("R2 ch1 ran", v, 69);
    rd(ra(0, 5), v); chk("R2 ch0 held", v, 0);
    wr(8'h00, 16'h5); rd(8'h00, v); chk("R2 run readback", v, 5);
    wr(8'h00, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    wr(ra(2, 2), 16'h7);
    t_static;
    t_regmap;
    t_prescale;
    t_clear;
    t_normal;
    t_pwm;
    t_resume;
    t_indep;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule